// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block lets a compiler hoist loads above stores that might write the same memory. When a hoisted ("advanced") load executes, it records its destination register tag and its load address in a small fully associative table. Every store address is then compared against all live entries. Any entry whose address falls in the same 8-byte block as the store is dropped. When the value is about to be consumed, a check for the register tag is issued. If the entry is still live, the speculative value is good and nothing has to happen. If the entry is gone, the consumer must reload from the address it supplies with the check.

An entry can disappear for three reasons: a conflicting store, a check that asks for the entry to be cleared after it hits, or displacement by a newer insert when the table is full. A miss never means a fault. It only means the value must be fetched again.

Inserts, store snoops and checks may all arrive in the same cycle. Checks and slot selection see the table as it stood at the start of that cycle. Updates are then applied in a fixed order: store invalidation first, then clear-on-check, then the insert write. The check response is registered and appears exactly one cycle after the check.

Top module: `ldspec_table`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer is at entry 0, `rsp_valid` is low, and the first check of any tag reports a miss.
- R2: A check of a tag whose entry is live returns `rsp_hit`=1 and `rsp_reload`=0.
- R3: A check of a tag with no live entry returns `rsp_hit`=0 and `rsp_reload`=1, with `rsp_addr` equal to the `chk_addr` given with that check.
- R4: A store invalidates every live entry whose address matches the store address in bits [31:3]. Bits [2:0] are ignored, so a partial overlap within the 8-byte block also invalidates.
- R5: A store whose address differs from an entry's address in bits [31:3] leaves that entry live.
- R6: An insert whose tag is already live overwrites that entry's address. A tag is never held by two live entries.
- R7: An insert with a new tag takes the lowest-numbered free entry. When no entry is free, it replaces the entry at the round-robin pointer, and the pointer then advances by one, wrapping after the last entry.
- R8: When an insert and a matching store arrive in the same cycle, the store is applied first and the newly inserted entry stays live.
- R9: A check with `chk_clear`=1 that hits reports the hit and invalidates the entry, so a later check of that tag misses.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `chk_valid` high. A check sees the table as it was before updates made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Record an advanced load this cycle |
| ins_tag | input | 7 | Destination register tag of the load |
| ins_addr | input | 32 | Load address |
| st_valid | input | 1 | Store snoop this cycle |
| st_addr | input | 32 | Store address |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | 7 | Register tag to check |
| chk_addr | input | 32 | Address to reload from on a miss |
| chk_clear | input | 1 | Invalidate the entry if the check hits |
| rsp_valid | output | 1 | Check response valid (one cycle after the check) |
| rsp_hit | output | 1 | Entry was live, so no action is needed |
| rsp_reload | output | 1 | Entry was absent, so the value must be reloaded |
| rsp_addr | output | 32 | Reload address |

## Verification
The bench builds the table with its defaults: 8 entries, 7-bit tags, 32-bit addresses and 8-byte comparison blocks. Random tags are drawn from a pool of twelve, which is larger than the table, so the table fills, round-robin eviction happens, and the pointer wraps many times within a few thousand cycles. Addresses come from a handful of 8-byte blocks with random low bits, so partial-overlap invalidation, same-cycle insert and store collisions, and clear-on-check are all reached often alongside the directed cases.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

    // Where an insert lands this cycle
    typedef enum logic [1:0] {
        SRC_NONE,   // no insert
        SRC_REUSE,  // tag already live: overwrite that entry
        SRC_FREE,   // lowest invalid entry
        SRC_EVICT   // table full: round-robin victim
    } slot_src_e;

endpackage

// File: rtl/ldspec_match.sv
module ldspec_match #(
    parameter int N      = 8,
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int GRAN   = 3
) (
    input  logic [N-1:0]             vld,
    input  logic [N-1:0][TAG_W-1:0]  tags,
    input  logic [N-1:0][ADDR_W-1:0] addrs,
    input  logic [TAG_W-1:0]         chk_tag,
    input  logic [TAG_W-1:0]         ins_tag,
    input  logic [ADDR_W-1:0]        st_addr,
    output logic [N-1:0]             chk_hit_v,
    output logic [N-1:0]             ins_hit_v,
    output logic [N-1:0]             st_hit_v
);
    localparam int BLK_W = ADDR_W - GRAN;

    for (genvar e = 0; e < N; e++) begin : g_ent
        logic [BLK_W-1:0] ent_blk;
        logic [BLK_W-1:0] st_blk;
        assign ent_blk      = addrs[e][ADDR_W-1:GRAN];
        assign st_blk       = st_addr[ADDR_W-1:GRAN];
        assign chk_hit_v[e] = vld[e] && (tags[e] == chk_tag);
        assign ins_hit_v[e] = vld[e] && (tags[e] == ins_tag);
        assign st_hit_v[e]  = vld[e] && (ent_blk == st_blk);
    end

endmodule

// File: rtl/ldspec_alloc.sv
module ldspec_alloc
    import ldspec_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     ins_hit_v,
    output logic [IDX_W-1:0] slot,
    output slot_src_e        src
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] reuse_idx;
    logic             free_found;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        reuse_idx  = '0;
        for (int e = N - 1; e >= 0; e--) begin
            if (!vld[e]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(e);
            end
            if (ins_hit_v[e]) reuse_idx = IDX_W'(e);
        end
    end

    always_comb begin
        if (!ins_valid)      src = SRC_NONE;
        else if (|ins_hit_v) src = SRC_REUSE;
        else if (free_found) src = SRC_FREE;
        else                 src = SRC_EVICT;
    end

    always_comb begin
        unique case (src)
            SRC_REUSE: slot = reuse_idx;
            SRC_FREE:  slot = free_idx;
            SRC_EVICT: slot = rr_q;
            default:   slot = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rr_q <= '0;
        else if (src == SRC_EVICT) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R7
    rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EVICT) |=> rr_q == (($past(rr_q) == IDX_W'(N - 1)) ? '0 : $past(rr_q) + 1'b1));

    // R7
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_EVICT) |=> $stable(rr_q));

endmodule

// File: rtl/ldspec_table.sv
module ldspec_table
    import ldspec_pkg::*;
#(
    parameter int N      = 8,
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int GRAN   = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_clear,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_reload,
    output logic [ADDR_W-1:0] rsp_addr
);
    logic [N-1:0]             vld_q, vld_d;
    logic [N-1:0][TAG_W-1:0]  tag_q;
    logic [N-1:0][ADDR_W-1:0] addr_q;
    logic [N-1:0]             chk_hit_v, ins_hit_v, st_hit_v;
    logic [IDX_W-1:0]         slot;
    slot_src_e                src;

    ldspec_match #(.N(N), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .GRAN(GRAN)) u_match (
        .vld       (vld_q),
        .tags      (tag_q),
        .addrs     (addr_q),
        .chk_tag   (chk_tag),
        .ins_tag   (ins_tag),
        .st_addr   (st_addr),
        .chk_hit_v (chk_hit_v),
        .ins_hit_v (ins_hit_v),
        .st_hit_v  (st_hit_v)
    );

    ldspec_alloc #(.N(N)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .vld       (vld_q),
        .ins_hit_v (ins_hit_v),
        .slot      (slot),
        .src       (src)
    );

    // Update order: store snoop, then clear-on-check, then insert write
    always_comb begin
        vld_d = vld_q;
        for (int e = 0; e < N; e++) begin
            if (st_valid && st_hit_v[e])                 vld_d[e] = 1'b0;
            if (chk_valid && chk_clear && chk_hit_v[e])  vld_d[e] = 1'b0;
        end
        if (src != SRC_NONE) vld_d[slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (src != SRC_NONE) begin
            tag_q[slot]  <= ins_tag;
            addr_q[slot] <= ins_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_reload <= 1'b0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid  <= chk_valid;
            rsp_hit    <= chk_valid && (|chk_hit_v);
            rsp_reload <= chk_valid && !(|chk_hit_v);
            rsp_addr   <= chk_addr;
        end
    end

    // R6
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_hit_v));

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);

    // R8
    ins_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> vld_q[$past(slot)]);

    // R4
    store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !ins_valid) |=> ((vld_q & $past(st_hit_v)) == '0));

    // R9
    clear_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_clear && !ins_valid) |=> ((vld_q & $past(chk_hit_v)) == '0));

endmodule

// File: tb/tb_ldspec_table.sv
module tb_ldspec_table;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid, st_valid, chk_valid, chk_clear;
    logic [6:0]  ins_tag, chk_tag;
    logic [31:0] ins_addr, st_addr, chk_addr;
    logic        rsp_valid, rsp_hit, rsp_reload;
    logic [31:0] rsp_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state of the table
    bit          m_v[N];
    logic [6:0]  m_t[N];
    logic [31:0] m_a[N];
    int          m_rr;

    always #10 clk = ~clk;

    ldspec_table #(.N(N), .TAG_W(7), .ADDR_W(32), .GRAN(3)) dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_addr(chk_addr), .chk_clear(chk_clear),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reload(rsp_reload), .rsp_addr(rsp_addr)
    );

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pick_slot(logic [6:0] tag, output bit evict);
        evict = 1'b0;
        for (int e = 0; e < N; e++) if (m_v[e] && m_t[e] == tag) return e;
        for (int e = 0; e < N; e++) if (!m_v[e]) return e;
        evict = 1'b1;
        return m_rr;
    endfunction

    // One cycle: drive at the falling edge, predict, check the response one edge later
    task automatic cycle(bit ins, logic [6:0] itag, logic [31:0] iaddr,
                         bit st, logic [31:0] saddr,
                         bit chk, logic [6:0] ctag, logic [31:0] caddr, bit clr,
                         string req);
        bit exp_hit = 1'b0;
        int hidx = -1;
        int slot = 0;
        bit evict = 1'b0;
        ins_valid = ins; ins_tag = itag; ins_addr = iaddr;
        st_valid = st; st_addr = saddr;
        chk_valid = chk; chk_tag = ctag; chk_addr = caddr; chk_clear = clr;
        for (int e = 0; e < N; e++)
            if (m_v[e] && m_t[e] == ctag) begin exp_hit = 1'b1; hidx = e; end
        if (ins) slot = pick_slot(itag, evict);
        if (st)
            for (int e = 0; e < N; e++)
                if (m_v[e] && m_a[e][31:3] == saddr[31:3]) m_v[e] = 1'b0;
        if (chk && clr && hidx >= 0) m_v[hidx] = 1'b0;
        if (ins) begin
            m_v[slot] = 1'b1; m_t[slot] = itag; m_a[slot] = iaddr;
            if (evict) m_rr = (m_rr + 1) % N;
        end
        @(negedge clk);
        check_eq(req, "rsp_valid", 32'(rsp_valid), 32'(chk));
        if (chk) begin
            check_eq(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
            check_eq(req, "rsp_reload", 32'(rsp_reload), 32'(!exp_hit));
            if (!exp_hit) check_eq(req, "rsp_addr", rsp_addr, caddr);
        end
    endtask

    task automatic idle_chk(logic [6:0] tag, logic [31:0] a, bit clr, string req);
        cycle(0, 0, 0, 0, 0, 1, tag, a, clr, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ins_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0;
        ins_tag = 0; chk_tag = 0; ins_addr = 0; st_addr = 0; chk_addr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < N; e++) m_v[e] = 1'b0;
        m_rr = 0;
        check_eq("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        do_reset();
        // R1: empty table misses
        idle_chk(7'd5, 32'h0000_0500, 0, "R1");
        // R2: insert then hit
        cycle(1, 7'd10, 32'h1000, 0, 0, 0, 0, 0, 0, "R2");
        idle_chk(7'd10, 32'h1000, 0, "R2");
        // R3: unknown tag misses and echoes address
        idle_chk(7'd11, 32'h2220, 0, "R3");
        // R4: partial overlap kills the entry
        cycle(0, 0, 0, 1, 32'h1006, 0, 0, 0, 0, "R4");
        idle_chk(7'd10, 32'h1000, 0, "R4");
        // R5: neighbouring block leaves it alone
        cycle(1, 7'd10, 32'h1000, 1, 32'h1008, 0, 0, 0, 0, "R5");
        idle_chk(7'd10, 32'h1000, 0, "R5");
        // R6: overwrite moves the tracked address
        cycle(1, 7'd10, 32'h3000, 0, 0, 0, 0, 0, 0, "R6");
        cycle(0, 0, 0, 1, 32'h1000, 1, 7'd10, 32'h3000, 0, "R6");
        cycle(0, 0, 0, 1, 32'h3004, 0, 0, 0, 0, "R6");
        idle_chk(7'd10, 32'h3000, 0, "R6");
        // R8: insert and matching store in one cycle
        cycle(1, 7'd20, 32'h4000, 1, 32'h4000, 0, 0, 0, 0, "R8");
        idle_chk(7'd20, 32'h4000, 0, "R8");
        // R9: clear on hit
        idle_chk(7'd20, 32'h4000, 1, "R9");
        idle_chk(7'd20, 32'h4000, 0, "R9");
        // R10: same-cycle insert is not seen by the check
        cycle(1, 7'd30, 32'h5000, 0, 0, 1, 7'd30, 32'h5000, 0, "R10");
        idle_chk(7'd30, 32'h5000, 0, "R10");
        // R4: one store drops two entries in the same block
        cycle(1, 7'd31, 32'h5004, 0, 0, 0, 0, 0, 0, "R4");
        cycle(0, 0, 0, 1, 32'h5002, 0, 0, 0, 0, "R4");
        idle_chk(7'd30, 32'h5000, 0, "R4");
        idle_chk(7'd31, 32'h5004, 0, "R4");
        // R7: fill, then round-robin eviction from entry 0
        do_reset();
        for (int i = 0; i < N; i++)
            cycle(1, 7'(40 + i), 32'(32'h6000 + 16 * i), 0, 0, 0, 0, 0, 0, "R7");
        cycle(1, 7'd48, 32'h7000, 0, 0, 0, 0, 0, 0, "R7");
        idle_chk(7'd40, 32'h6000, 0, "R7");
        idle_chk(7'd41, 32'h6010, 0, "R7");
        cycle(1, 7'd49, 32'h7010, 0, 0, 0, 0, 0, 0, "R7");
        idle_chk(7'd41, 32'h6010, 0, "R7");
        idle_chk(7'd42, 32'h6020, 0, "R7");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit ins = ($urandom % 3) == 0;
            bit st  = ($urandom % 4) == 0;
            bit chk = ($urandom % 2) == 0;
            bit clr = ($urandom % 5) == 0;
            logic [6:0]  it = 7'($urandom % 12);
            logic [6:0]  ct = 7'($urandom % 12);
            logic [31:0] ia = 32'h100 + (($urandom % 6) << 3) + ($urandom % 8);
            logic [31:0] sa = 32'h100 + (($urandom % 6) << 3) + ($urandom % 8);
            logic [31:0] ca = 32'h100 + (($urandom % 6) << 3);
            cycle(ins, it, ia, st, sa, chk, ct, ca, clr, "R2 R3 R7 R10");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule